// File: doc/BRIEF.md
# Quad SPI Flash Controller Configuration Register

This block holds the main 32-bit configuration word of a quad SPI flash controller and drives the logic that hangs directly off it. A simple bus writes the word with per-lane byte enables and reads it back. The block decodes the peripheral-select field into four active-low chip selects. That decode is either a lowest-zero priority one-hot or a straight pass-through for a board-level 4-to-16 decoder. The block also carries the write-protect bit into the flash clock domain and reports a retimed idle flag in the top bit.

The controller enable and the direct-access enable are both deferred on the way down. Software can clear either bit at any time, but the effective signal holds until the serial engine signals the end of the word in flight. The effective signal then drops in the same cycle as that pulse. Setting either bit takes effect at once. The effective controller enable gates every pin output enable. A flash data request seen while direct access is effectively off and the indirect path is off gets an error response.

Top module: `qspi_cfg_ctrl`

## Requirements
- R1: After reset the word reads 0x8078_0000: idle (bit 31) is 1, the clock divisor field (bits 22:19) is 0xF, every other field is 0, and the effective enables, write-protect pin and error flag are 0.
- R2: Bits 30:23 and 6:3 always read 0, and bit 31 cannot be written. Writing all ones with all lanes enabled reads back 0x807F_FF87 while the engine is idle.
- R3: A write changes only the bytes whose enable bit is set (enable bit i covers data bits 8i+7:8i). A write to any address other than 0 changes nothing.
- R4: With the decode-mode bit (bit 9) at 0, the select field s (bits 13:10) maps to cs_n as follows: bit i of cs_n is 0 only when s[i] is 0 and all lower bits of s are 1. For example, s=xxx0 gives 1110, xx01 gives 1101, x011 gives 1011, 0111 gives 0111, and 1111 gives 1111.
- R5: With the decode-mode bit at 1, cs_n equals the select field bit for bit.
- R6: Setting the enable bit (bit 0) raises run_en at the next clock edge. Clearing it leaves run_en high until word_done is 1, and run_en falls combinationally in that same cycle.
- R7: oe_en equals the effective enable, so all pin output enables are off while the controller is effectively disabled.
- R8: The direct-access bit (bit 7) is deferred in the same way as R6 and drives dir_en. bus_err is 1 exactly when bus_req is 1, dir_en is 0 and indirect_en is 0.
- R9: wp_pin follows the write-protect bit (bit 14) through a SYNC_STAGES flip-flop chain clocked by mem_clk. It is still at its old value on the first falling edge of clk after the write.
- R10: Bit 31 reads the inverse of eng_busy delayed by IDLE_LAT clk cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_clk | input | 1 | Generated flash clock |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Word address; the register sits at 0 |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write enables |
| bus_rdata | output | 32 | Register read value |
| bus_req | input | 1 | Flash data request from the bus |
| indirect_en | input | 1 | Indirect access path enabled |
| word_done | input | 1 | End-of-word pulse from the serial engine |
| eng_busy | input | 1 | Serial engine busy |
| run_en | output | 1 | Effective controller enable |
| dir_en | output | 1 | Effective direct-access enable |
| oe_en | output | 1 | Pin output-enable gating |
| clk_pol | output | 1 | Clock polarity field |
| clk_phase | output | 1 | Clock phase field |
| legacy_mode | output | 1 | Legacy pass-through mode field |
| ext_dec | output | 1 | Decode-mode field |
| ps_sel | output | 4 | Peripheral-select field |
| dma_en | output | 1 | DMA handshake enable field |
| remap_en | output | 1 | Address remap enable field |
| xip_next | output | 1 | Enter execute-in-place on next read field |
| xip_imm | output | 1 | Execute-in-place immediately field |
| baud_div | output | 4 | Clock divisor field |
| cs_n | output | 4 | Active-low chip selects |
| wp_pin | output | 1 | Write-protect pin, mem_clk domain |
| bus_err | output | 1 | Error response for the current request |

## Verification
The bench builds the block with AW=4, SYNC_STAGES=2 and IDLE_LAT=2. With two stages, the lag of the idle flag can be checked edge by edge: it is still 1 one cycle after busy rises and 0 after the second. A mem_clk of 14 ns shows that the write-protect pin has not yet moved one half-cycle after the write, and that it settles within a few flash clock edges. The four-bit address space leaves unused addresses open for the ignored-write check. All 16 select codes are not needed to reach the priority boundaries, so the vector table samples each boundary of the decode in both modes.

// File: rtl/qspi_cfg_pkg.sv
package qspi_cfg_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned NCS    = 4;

  // Field layout of the configuration word; positions are software-visible.
  typedef struct packed {
    logic       idle;       // 31
    logic [7:0] resv_hi;    // 30:23
    logic [3:0] baud;       // 22:19
    logic       xip_imm;    // 18
    logic       xip_next;   // 17
    logic       remap;      // 16
    logic       dma;        // 15
    logic       wprot;      // 14
    logic [3:0] psel;       // 13:10
    logic       ext_dec;    // 9
    logic       legacy;     // 8
    logic       direct;     // 7
    logic [3:0] resv_lo;    // 6:3
    logic       phase;      // 2
    logic       pol;        // 1
    logic       enable;     // 0
  } cfg_word_t;

  // Bits software may change.
  localparam logic [WORD_W-1:0] WR_MASK   = 32'h007F_FF87;
  // Stored reset image; bit 31 comes from the idle retimer.
  localparam logic [WORD_W-1:0] RST_IMAGE = 32'h0078_0000;

endpackage

// File: rtl/qspi_cfg_regfile.sv
module qspi_cfg_regfile
  import qspi_cfg_pkg::*;
#(
  parameter int unsigned AW       = 4,
  parameter logic [AW-1:0] MY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  be,
  output logic [WORD_W-1:0] word_q
);

  logic              hit;
  logic [WORD_W-1:0] word_d;
  logic [LANES-1:0]  lane_we;

  assign hit = wr && (addr == MY_ADDR);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lmask;
    assign lmask      = WR_MASK[8*g +: 8];
    assign lane_we[g] = hit & be[g];
    always_comb begin
      if (lane_we[g]) begin
        word_d[8*g +: 8] = (wdata[8*g +: 8] & lmask) | (word_q[8*g +: 8] & ~lmask);
      end else begin
        word_d[8*g +: 8] = word_q[8*g +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= RST_IMAGE;
    end else if (hit) begin
      word_q <= word_d;
    end
  end

endmodule

// File: rtl/qspi_defer_off.sv
// Enable that rises at once and falls only on the end-of-word pulse.
module qspi_defer_off (
  input  logic clk,
  input  logic rst_n,
  input  logic req_on,
  input  logic word_done,
  output logic eff_on,
  output logic off_pending
);

  logic held_q;
  logic held_d;

  always_comb begin
    eff_on      = req_on | (held_q & ~word_done);
    off_pending = held_q & ~req_on;
    held_d      = eff_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else begin
      held_q <= held_d;
    end
  end

endmodule

// File: rtl/qspi_cs_decode.sv
module qspi_cs_decode #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] sel,
  input  logic         passthru,
  output logic [N-1:0] cs_n
);

  logic [N-1:0] prio_n;
  logic [N:0]   lower_ones;

  assign lower_ones[0] = 1'b1;
  for (genvar i = 0; i < N; i++) begin : g_prio
    assign prio_n[i]       = ~(~sel[i] & lower_ones[i]);
    assign lower_ones[i+1] = lower_ones[i] & sel[i];
  end

  assign cs_n = passthru ? sel : prio_n;

endmodule

// File: rtl/qspi_sync_chain.sv
module qspi_sync_chain #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  if (STAGES == 1) begin : g_one
    assign sh_d = din;
  end else begin : g_many
    assign sh_d = {sh_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= {STAGES{RST_VAL}};
    end else begin
      sh_q <= sh_d;
    end
  end

  assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/qspi_cfg_ctrl.sv
module qspi_cfg_ctrl
  import qspi_cfg_pkg::*;
#(
  parameter int unsigned AW          = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_LAT    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_clk,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic [3:0]    bus_be,
  output logic [31:0]   bus_rdata,
  input  logic          bus_req,
  input  logic          indirect_en,
  input  logic          word_done,
  input  logic          eng_busy,
  output logic          run_en,
  output logic          dir_en,
  output logic          oe_en,
  output logic          clk_pol,
  output logic          clk_phase,
  output logic          legacy_mode,
  output logic          ext_dec,
  output logic [3:0]    ps_sel,
  output logic          dma_en,
  output logic          remap_en,
  output logic          xip_next,
  output logic          xip_imm,
  output logic [3:0]    baud_div,
  output logic [3:0]    cs_n,
  output logic          wp_pin,
  output logic          bus_err
);

  logic [WORD_W-1:0] word_q;
  cfg_word_t         cfg;
  logic              idle_q;
  logic              run_pend;
  logic              dir_pend;

  qspi_cfg_regfile #(.AW(AW), .MY_ADDR('0)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .be     (bus_be),
    .word_q (word_q)
  );

  assign cfg = cfg_word_t'(word_q);

  qspi_defer_off u_run (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_on      (cfg.enable),
    .word_done   (word_done),
    .eff_on      (run_en),
    .off_pending (run_pend)
  );

  qspi_defer_off u_dir (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_on      (cfg.direct),
    .word_done   (word_done),
    .eff_on      (dir_en),
    .off_pending (dir_pend)
  );

  qspi_cs_decode #(.N(NCS)) u_cs (
    .sel      (cfg.psel),
    .passthru (cfg.ext_dec),
    .cs_n     (cs_n)
  );

  qspi_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wp_sync (
    .clk   (mem_clk),
    .rst_n (rst_n),
    .din   (cfg.wprot),
    .dout  (wp_pin)
  );

  qspi_sync_chain #(.STAGES(IDLE_LAT), .RST_VAL(1'b1)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (~eng_busy),
    .dout  (idle_q)
  );

  always_comb begin
    bus_rdata     = word_q;
    bus_rdata[31] = idle_q;
  end

  assign oe_en       = run_en;
  assign bus_err     = bus_req & ~dir_en & ~indirect_en;
  assign clk_pol     = cfg.pol;
  assign clk_phase   = cfg.phase;
  assign legacy_mode = cfg.legacy;
  assign ext_dec     = cfg.ext_dec;
  assign ps_sel      = cfg.psel;
  assign dma_en      = cfg.dma;
  assign remap_en    = cfg.remap;
  assign xip_next    = cfg.xip_next;
  assign xip_imm     = cfg.xip_imm;
  assign baud_div    = cfg.baud;

endmodule

// File: rtl/qspi_cfg_checker.sv
module qspi_cfg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] bus_rdata,
  input logic        ext_dec,
  input logic [3:0]  ps_sel,
  input logic [3:0]  cs_n,
  input logic        run_en,
  input logic        dir_en,
  input logic        oe_en,
  input logic        word_done,
  input logic        bus_req,
  input logic        indirect_en,
  input logic        bus_err
);

  a_r2_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[30:23] == 8'h00) && (bus_rdata[6:3] == 4'h0));

  a_r4_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_dec |-> ($countones(~cs_n) <= 1));

  a_r5_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ext_dec |-> (cs_n == ps_sel));

  a_r6_fall_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_en) |-> word_done);

  a_r7_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    oe_en |-> run_en);

  a_r8_dir_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir_en) |-> word_done);

  a_r8_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !dir_en && !indirect_en) |-> bus_err);

  a_r8_err_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_req && !indirect_en));

endmodule

bind qspi_cfg_ctrl qspi_cfg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rdata   (bus_rdata),
  .ext_dec     (ext_dec),
  .ps_sel      (ps_sel),
  .cs_n        (cs_n),
  .run_en      (run_en),
  .dir_en      (dir_en),
  .oe_en       (oe_en),
  .word_done   (word_done),
  .bus_req     (bus_req),
  .indirect_en (indirect_en),
  .bus_err     (bus_err)
);

// File: tb/qspi_cfg_ctrl_test.sv
`timescale 1ns/1ps
module qspi_cfg_ctrl_test;

  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          mem_clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [3:0]    bus_be;
  logic [31:0]   bus_rdata;
  logic          bus_req, indirect_en, word_done, eng_busy;
  logic          run_en, dir_en, oe_en, clk_pol, clk_phase, legacy_mode, ext_dec;
  logic [3:0]    ps_sel, baud_div, cs_n;
  logic          dma_en, remap_en, xip_next, xip_imm, wp_pin, bus_err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;
  always #7 mem_clk = ~mem_clk;

  qspi_cfg_ctrl #(.AW(AW), .SYNC_STAGES(2), .IDLE_LAT(2)) uut (
    .clk(clk), .rst_n(rst_n), .mem_clk(mem_clk),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .bus_req(bus_req), .indirect_en(indirect_en),
    .word_done(word_done), .eng_busy(eng_busy), .run_en(run_en), .dir_en(dir_en),
    .oe_en(oe_en), .clk_pol(clk_pol), .clk_phase(clk_phase), .legacy_mode(legacy_mode),
    .ext_dec(ext_dec), .ps_sel(ps_sel), .dma_en(dma_en), .remap_en(remap_en),
    .xip_next(xip_next), .xip_imm(xip_imm), .baud_div(baud_div), .cs_n(cs_n),
    .wp_pin(wp_pin), .bus_err(bus_err)
  );

  // {ext_dec, select, expected cs_n}
  localparam logic [8:0] VEC [12] = '{
    {1'b0, 4'h0, 4'b1110}, {1'b0, 4'h1, 4'b1101}, {1'b0, 4'h2, 4'b1110},
    {1'b0, 4'h3, 4'b1011}, {1'b0, 4'h7, 4'b0111}, {1'b0, 4'hF, 4'b1111},
    {1'b0, 4'hB, 4'b1011}, {1'b0, 4'h5, 4'b1101}, {1'b1, 4'hF, 4'b1111},
    {1'b1, 4'h5, 4'b0101}, {1'b1, 4'hA, 4'b1010}, {1'b1, 4'h0, 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
    bus_req = 1'b0; indirect_en = 1'b0; word_done = 1'b0; eng_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 word", bus_rdata, 32'h8078_0000);
    check("R1 baud", {28'h0, baud_div}, 32'hF);
    check("R1 run/dir/wp/err", {28'h0, run_en, dir_en, wp_pin, bus_err}, 32'h0);
    check("R4 reset cs", {28'h0, cs_n}, 32'hE);

    // R4 / R5 decode table
    for (int i = 0; i < 12; i++) begin
      wr('0, {18'h0, VEC[i][7:4], VEC[i][8], 9'h0}, 4'hF);
      check(VEC[i][8] ? "R5 passthru" : "R4 priority", {28'h0, cs_n}, {28'h0, VEC[i][3:0]});
    end

    // R6 / R7 deferred enable
    wr('0, 32'h1, 4'hF);
    check("R6 enable rises", {30'h0, run_en, oe_en}, 32'h3);
    wr('0, 32'h0, 4'hF);
    check("R6 held after clear", {31'h0, run_en}, 32'h1);
    repeat (2) @(negedge clk);
    check("R7 oe held", {31'h0, oe_en}, 32'h1);
    word_done = 1'b1; #1;
    check("R6 drop with pulse", {30'h0, run_en, oe_en}, 32'h0);
    @(negedge clk); word_done = 1'b0; #1;
    check("R6 stays off", {30'h0, run_en, oe_en}, 32'h0);

    // R8 direct enable and error response
    bus_req = 1'b1; #1;
    check("R8 err both off", {31'h0, bus_err}, 32'h1);
    wr('0, 32'h80, 4'hF);
    check("R8 err direct on", {30'h0, dir_en, bus_err}, 32'h2);
    wr('0, 32'h0, 4'hF);
    check("R8 direct clear deferred", {30'h0, dir_en, bus_err}, 32'h2);
    word_done = 1'b1; #1;
    check("R8 err at word end", {30'h0, dir_en, bus_err}, 32'h1);
    @(negedge clk); word_done = 1'b0; indirect_en = 1'b1; #1;
    check("R8 indirect masks err", {31'h0, bus_err}, 32'h0);
    bus_req = 1'b0; indirect_en = 1'b0;

    // R9 write-protect synchronizer
    wr('0, 32'h4000, 4'hF);
    check("R9 wp not yet", {31'h0, wp_pin}, 32'h0);
    repeat (4) @(posedge mem_clk); #1;
    check("R9 wp set", {31'h0, wp_pin}, 32'h1);
    wr('0, 32'h0, 4'hF);
    repeat (4) @(posedge mem_clk); #1;
    check("R9 wp clear", {31'h0, wp_pin}, 32'h0);

    // R10 idle retiming
    @(negedge clk); eng_busy = 1'b1;
    @(negedge clk);
    check("R10 idle lag", {31'h0, bus_rdata[31]}, 32'h1);
    @(negedge clk);
    check("R10 idle low", {31'h0, bus_rdata[31]}, 32'h0);
    eng_busy = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 idle back", {31'h0, bus_rdata[31]}, 32'h1);

    // R3 byte lanes and address decode
    wr('0, 32'hFFFF_FFFF, 4'b0100);
    check("R3 lane 2 only", bus_rdata, 32'h807F_0000);
    wr(4'h3, 32'h0, 4'hF);
    check("R3 wrong address", bus_rdata, 32'h807F_0000);

    // R2 reserved and read-only bits
    wr('0, 32'hFFFF_FFFF, 4'hF);
    check("R2 reserved zero", bus_rdata, 32'h807F_FF87);
    check("R6 set by full write", {31'h0, run_en}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule